// File: doc/BRIEF.md
# Branch Next-PC and Link Unit

This block decides where instruction flow goes after a branch on a 32-bit machine whose instructions are all 4 bytes wide. Each cycle it takes the address of the current instruction and a decoded branch request. It returns the next program counter, a taken flag, and write requests for the link register and the count register. The branch request covers the target mode, an optional test of one condition bit, an optional count-register decrement, a link request and the encoded displacement. The block also receives the current condition bits and the link and count register values.

Four target modes are supported. The first is PC-relative, using a word displacement. The second is absolute, using a word address. The last two take the target from the link register or from the count register. Any branch may test one condition bit for a required value. Any branch may decrement the count register and require the new value to be nonzero. Any branch may save its return address. Outputs are registered, so a request presented before a clock edge appears at the outputs after that edge. The register file update and instruction fetch belong to the surrounding pipeline.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become `next_pc_o` = `RESET_PC` (default 0x0000_0100) with `taken_o`, `lr_we_o` and `ctr_we_o` low.
- R2: Kind code 1 (relative) aims at `pc_i` plus the 24-bit two's-complement `disp_i` shifted left by 2, with the sum wrapping modulo 2^32.
- R3: Kind code 2 (absolute) aims at the sign-extended `disp_i` shifted left by 2, independent of `pc_i`.
- R4: Kind code 3 aims at `lr_i` and kind code 4 aims at `ctr_i`, in both cases with address bits [1:0] cleared. When the count register is also decremented, the pre-decrement value is used.
- R5: With `cond_en_i` high, the branch is taken only if bit `cond_sel_i` of `cr_i` equals `cond_pol_i`. Bit 0 is the least significant bit.
- R6: With `ctr_dec_i` high on a branch kind, `ctr_we_o` is raised with `ctr_wdata_o` = `ctr_i` − 1 (wrapping), taken or not. The branch is taken only if that new value is nonzero and any condition test also passes.
- R7: With `link_i` high on a branch kind, `lr_we_o` is raised with `lr_wdata_o` = `pc_i` + 4, whether or not the branch is taken. A link-register target uses the old `lr_i`.
- R8: A branch that is not taken gives `next_pc_o` = `pc_i` + 4. Kind code 0 and the unused codes 5 to 7 are never taken and ignore `link_i` and `ctr_dec_i`, with both write enables low.
- R9: Results appear one clock edge after their request, and the outputs hold the previous result until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Address of the branch instruction |
| kind_i | input | 3 | Target mode: 0 none, 1 relative, 2 absolute, 3 link register, 4 count register |
| cond_en_i | input | 1 | Apply the condition-bit test |
| cond_sel_i | input | 5 | Index of the condition bit to test |
| cond_pol_i | input | 1 | Value the selected bit must have |
| ctr_dec_i | input | 1 | Decrement count register and require nonzero |
| link_i | input | 1 | Save return address in the link register |
| disp_i | input | 24 | Word displacement or word address |
| cr_i | input | 32 | Condition bits |
| lr_i | input | 32 | Current link register value |
| ctr_i | input | 32 | Current count register value |
| next_pc_o | output | 32 | Next program counter |
| taken_o | output | 1 | Branch taken |
| lr_we_o | output | 1 | Link register write enable |
| lr_wdata_o | output | 32 | Link register write value |
| ctr_we_o | output | 1 | Count register write enable |
| ctr_wdata_o | output | 32 | Count register write value |

## Verification
The hardest cases are the ones where several options combine on one request. A count loop must exit because the decremented value reaches zero while its condition test still passes. A count of zero must wrap and keep branching. A failed condition must still link and still decrement. The table places these combinations in adjacent vectors that differ only in the count or condition value, so each exit path is seen against its neighbour. Unused kind codes carrying link and decrement requests, and a relative branch that wraps past the top of the address space, round out the boundary vectors.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

    // Bytes per instruction; the fall-through step.
    localparam int INSTR_BYTES = 4;

    typedef enum logic [2:0] {
        BK_NONE = 3'd0,
        BK_REL  = 3'd1,
        BK_ABS  = 3'd2,
        BK_LR   = 3'd3,
        BK_CTR  = 3'd4
    } br_kind_e;

    typedef struct packed {
        logic is_branch;
        logic cond_ok;
        logic count_ok;
        logic take;
        logic link_we;
        logic ctr_we;
    } br_decision_t;

    // Unused codes collapse onto "no branch".
    function automatic br_kind_e decode_kind(input logic [2:0] raw);
        case (raw)
            3'd1:    return BK_REL;
            3'd2:    return BK_ABS;
            3'd3:    return BK_LR;
            3'd4:    return BK_CTR;
            default: return BK_NONE;
        endcase
    endfunction

    function automatic logic kind_is_indirect(input br_kind_e k);
        return (k == BK_LR) || (k == BK_CTR);
    endfunction

endpackage

// File: rtl/nextpc_target.sv
module nextpc_target
    import nextpc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 24
) (
    input  br_kind_e            kind_i,
    input  logic [ADDR_W-1:0]   pc_i,
    input  logic [DISP_W-1:0]   disp_i,
    input  logic [ADDR_W-1:0]   lr_i,
    input  logic [ADDR_W-1:0]   ctr_i,
    output logic [ADDR_W-1:0]   target_o
);
    localparam int SHIFT = $clog2(INSTR_BYTES);
    localparam int BYTE_DISP_W = DISP_W + SHIFT;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(INSTR_BYTES - 1);

    logic [BYTE_DISP_W-1:0] byte_disp;
    logic [ADDR_W-1:0]      offset;

    assign byte_disp = {disp_i, SHIFT'(0)};

    // Sign-extend or truncate the byte displacement to the address width.
    generate
        if (BYTE_DISP_W >= ADDR_W) begin : g_trunc
            assign offset = byte_disp[ADDR_W-1:0];
        end else begin : g_sext
            assign offset = {{(ADDR_W-BYTE_DISP_W){disp_i[DISP_W-1]}}, byte_disp};
        end
    endgenerate

    always_comb begin
        case (kind_i)
            BK_REL:  target_o = pc_i + offset;
            BK_ABS:  target_o = offset;
            BK_LR:   target_o = lr_i & ALIGN_MASK;
            BK_CTR:  target_o = ctr_i & ALIGN_MASK;
            default: target_o = pc_i + ADDR_W'(INSTR_BYTES);
        endcase
    end

endmodule

// File: rtl/nextpc_cond.sv
module nextpc_cond
    import nextpc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CR_W   = 32,
    parameter int CIDX_W = $clog2(CR_W)
) (
    input  br_kind_e            kind_i,
    input  logic                cond_en_i,
    input  logic [CIDX_W-1:0]   cond_sel_i,
    input  logic                cond_pol_i,
    input  logic                ctr_dec_i,
    input  logic                link_i,
    input  logic [CR_W-1:0]     cr_i,
    input  logic [ADDR_W-1:0]   ctr_i,
    output br_decision_t        decision_o,
    output logic [ADDR_W-1:0]   ctr_next_o
);
    logic sel_bit;
    logic sel_valid;

    assign sel_valid  = (32'(cond_sel_i) < CR_W);
    assign sel_bit    = sel_valid ? cr_i[cond_sel_i] : 1'b0;
    assign ctr_next_o = ctr_i - ADDR_W'(1);

    always_comb begin
        decision_o.is_branch = (kind_i != BK_NONE);
        decision_o.cond_ok   = !cond_en_i || (sel_bit == cond_pol_i);
        decision_o.count_ok  = !ctr_dec_i || (ctr_next_o != '0);
        decision_o.take      = decision_o.is_branch && decision_o.cond_ok
                               && decision_o.count_ok;
        decision_o.link_we   = decision_o.is_branch && link_i;
        decision_o.ctr_we    = decision_o.is_branch && ctr_dec_i;
    end

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
    import nextpc_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                DISP_W   = 24,
    parameter int                CR_W     = 32,
    parameter int                CIDX_W   = $clog2(CR_W),
    parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [2:0]        kind_i,
    input  logic              cond_en_i,
    input  logic [CIDX_W-1:0] cond_sel_i,
    input  logic              cond_pol_i,
    input  logic              ctr_dec_i,
    input  logic              link_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [CR_W-1:0]   cr_i,
    input  logic [ADDR_W-1:0] lr_i,
    input  logic [ADDR_W-1:0] ctr_i,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              taken_o,
    output logic              lr_we_o,
    output logic [ADDR_W-1:0] lr_wdata_o,
    output logic              ctr_we_o,
    output logic [ADDR_W-1:0] ctr_wdata_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    br_kind_e          kind;
    br_decision_t      dec;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] ctr_next;
    logic [ADDR_W-1:0] fall_pc;
    logic [ADDR_W-1:0] pc_d;
    logic              armed_q;

    assign kind    = decode_kind(kind_i);
    assign fall_pc = pc_i + STEP;

    nextpc_target #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) u_target (
        .kind_i   (kind),
        .pc_i     (pc_i),
        .disp_i   (disp_i),
        .lr_i     (lr_i),
        .ctr_i    (ctr_i),
        .target_o (target)
    );

    nextpc_cond #(
        .ADDR_W (ADDR_W),
        .CR_W   (CR_W),
        .CIDX_W (CIDX_W)
    ) u_cond (
        .kind_i     (kind),
        .cond_en_i  (cond_en_i),
        .cond_sel_i (cond_sel_i),
        .cond_pol_i (cond_pol_i),
        .ctr_dec_i  (ctr_dec_i),
        .link_i     (link_i),
        .cr_i       (cr_i),
        .ctr_i      (ctr_i),
        .decision_o (dec),
        .ctr_next_o (ctr_next)
    );

    assign pc_d = dec.take ? target : fall_pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc_o   <= RESET_PC;
            taken_o     <= 1'b0;
            lr_we_o     <= 1'b0;
            lr_wdata_o  <= '0;
            ctr_we_o    <= 1'b0;
            ctr_wdata_o <= '0;
            armed_q     <= 1'b0;
        end else begin
            next_pc_o   <= pc_d;
            taken_o     <= dec.take;
            lr_we_o     <= dec.link_we;
            lr_wdata_o  <= fall_pc;
            ctr_we_o    <= dec.ctr_we;
            ctr_wdata_o <= ctr_next;
            armed_q     <= 1'b1;
        end
    end

    // armed_q marks outputs that were loaded from a real request.
    p_fallthrough_r8: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !taken_o |-> next_pc_o == $past(pc_i) + STEP);

    p_none_quiet_r8: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(kind_i == 3'd0 || kind_i > 3'd4) |-> (!taken_o && !lr_we_o && !ctr_we_o));

    p_link_value_r7: assert property (@(posedge clk) disable iff (rst || !armed_q)
        lr_we_o |-> lr_wdata_o == $past(pc_i) + STEP);

    p_link_any_r7: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(link_i && kind_i != 3'd0 && kind_i <= 3'd4) |-> lr_we_o);

    p_ctr_value_r6: assert property (@(posedge clk) disable iff (rst || !armed_q)
        ctr_we_o |-> ctr_wdata_o == $past(ctr_i) - ADDR_W'(1));

    p_ctr_exit_r6: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(ctr_dec_i && ctr_i == ADDR_W'(1)) |-> !taken_o);

    p_indirect_align_r4: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (taken_o && ($past(kind_i) == 3'd3 || $past(kind_i) == 3'd4))
            |-> next_pc_o[1:0] == 2'b00);

    p_cond_block_r5: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(cond_en_i && cr_i[cond_sel_i] != cond_pol_i) |-> !taken_o);

endmodule

// File: tb/nextpc_unit_bench.sv
`timescale 1ns/1ps
module nextpc_unit_bench;

    localparam logic [31:0] RST_PC = 32'h0000_0100;

    typedef struct packed {
        logic [23:0] tag;
        logic [31:0] pc;
        logic [2:0]  kind;
        logic        cen;
        logic [4:0]  cidx;
        logic        pol;
        logic        dec;
        logic        lnk;
        logic [23:0] disp;
        logic [31:0] cr;
        logic [31:0] lr;
        logic [31:0] ctr;
        logic [31:0] npc;
        logic        tk;
        logic        lwe;
        logic [31:0] lwd;
        logic        cwe;
        logic [31:0] cwd;
    } vec_t;

    localparam int NV = 18;
    // tag, pc, kind, cen, cidx, pol, dec, lnk, disp, cr, lr, ctr | npc, tk, lwe, lwd, cwe, cwd
    localparam vec_t TBL [NV] = '{
        '{"R2 ", 32'h0000_1000, 3'd1, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 24'h000003, 32'h0, 32'h0, 32'h0,
          32'h0000_100C, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0},
        '{"R2 ", 32'h0000_2000, 3'd1, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 24'hFFFFFE, 32'h0, 32'h0, 32'h0,
          32'h0000_1FF8, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0},
        '{"R3 ", 32'h0000_3000, 3'd2, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 24'h000100, 32'h0, 32'h0, 32'h0,
          32'h0000_0400, 1'b1, 1'b1, 32'h0000_3004, 1'b0, 32'h0},
        '{"R4 ", 32'h0000_6000, 3'd3, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 24'h000000, 32'h0, 32'h0000_5003, 32'h0,
          32'h0000_5000, 1'b1, 1'b1, 32'h0000_6004, 1'b0, 32'h0},
        '{"R4 ", 32'h0000_0100, 3'd4, 1'b0, 5'd0,  1'b0, 1'b1, 1'b0, 24'h000000, 32'h0, 32'h0, 32'h0000_7006,
          32'h0000_7004, 1'b1, 1'b0, 32'h0, 1'b1, 32'h0000_7005},
        '{"R5 ", 32'h0000_0800, 3'd1, 1'b1, 5'd5,  1'b1, 1'b0, 1'b0, 24'h000004, 32'h20, 32'h0, 32'h0,
          32'h0000_0810, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0},
        '{"R7 ", 32'h0000_0800, 3'd1, 1'b1, 5'd5,  1'b1, 1'b0, 1'b1, 24'h000004, 32'h0, 32'h0, 32'h0,
          32'h0000_0804, 1'b0, 1'b1, 32'h0000_0804, 1'b0, 32'h0},
        '{"R5 ", 32'h0000_0900, 3'd1, 1'b1, 5'd1,  1'b0, 1'b0, 1'b0, 24'h000010, 32'h0, 32'h0, 32'h0,
          32'h0000_0940, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0},
        '{"R5 ", 32'h0000_0900, 3'd1, 1'b1, 5'd1,  1'b0, 1'b0, 1'b0, 24'h000010, 32'h2, 32'h0, 32'h0,
          32'h0000_0904, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
        '{"R6 ", 32'h0000_0A00, 3'd1, 1'b0, 5'd0,  1'b0, 1'b1, 1'b0, 24'h000008, 32'h0, 32'h0, 32'h1,
          32'h0000_0A04, 1'b0, 1'b0, 32'h0, 1'b1, 32'h0},
        '{"R6 ", 32'h0000_0B00, 3'd1, 1'b0, 5'd0,  1'b0, 1'b1, 1'b0, 24'h000008, 32'h0, 32'h0, 32'h0,
          32'h0000_0B20, 1'b1, 1'b0, 32'h0, 1'b1, 32'hFFFF_FFFF},
        '{"R6 ", 32'h0000_0C00, 3'd1, 1'b1, 5'd31, 1'b1, 1'b1, 1'b0, 24'h000002, 32'h8000_0000, 32'h0, 32'h5,
          32'h0000_0C08, 1'b1, 1'b0, 32'h0, 1'b1, 32'h4},
        '{"R6 ", 32'h0000_0C00, 3'd1, 1'b1, 5'd31, 1'b1, 1'b1, 1'b0, 24'h000002, 32'h0, 32'h0, 32'h5,
          32'h0000_0C04, 1'b0, 1'b0, 32'h0, 1'b1, 32'h4},
        '{"R8 ", 32'h0000_0D00, 3'd0, 1'b0, 5'd0,  1'b0, 1'b1, 1'b1, 24'h000006, 32'h0, 32'h0, 32'h9,
          32'h0000_0D04, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
        '{"R8 ", 32'h0000_0E00, 3'd7, 1'b0, 5'd0,  1'b0, 1'b1, 1'b1, 24'h000005, 32'h0, 32'h0, 32'h9,
          32'h0000_0E04, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
        '{"R2 ", 32'hFFFF_FFF8, 3'd1, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 24'h000004, 32'h0, 32'h0, 32'h0,
          32'h0000_0008, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0},
        '{"R4 ", 32'h0000_0200, 3'd4, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 24'h000000, 32'h0, 32'h0, 32'h0000_1237,
          32'h0000_1234, 1'b1, 1'b1, 32'h0000_0204, 1'b0, 32'h0},
        '{"R7 ", 32'h0000_0300, 3'd3, 1'b1, 5'd2,  1'b1, 1'b0, 1'b1, 24'h000000, 32'h0, 32'h0000_4000, 32'h0,
          32'h0000_0304, 1'b0, 1'b1, 32'h0000_0304, 1'b0, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_i = '0;
    logic [2:0]  kind_i = '0;
    logic        cond_en_i = 1'b0;
    logic [4:0]  cond_sel_i = '0;
    logic        cond_pol_i = 1'b0;
    logic        ctr_dec_i = 1'b0;
    logic        link_i = 1'b0;
    logic [23:0] disp_i = '0;
    logic [31:0] cr_i = '0;
    logic [31:0] lr_i = '0;
    logic [31:0] ctr_i = '0;
    logic [31:0] next_pc_o;
    logic        taken_o;
    logic        lr_we_o;
    logic [31:0] lr_wdata_o;
    logic        ctr_we_o;
    logic [31:0] ctr_wdata_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    nextpc_unit u_nextpc_unit (
        .clk         (clk),
        .rst         (rst),
        .pc_i        (pc_i),
        .kind_i      (kind_i),
        .cond_en_i   (cond_en_i),
        .cond_sel_i  (cond_sel_i),
        .cond_pol_i  (cond_pol_i),
        .ctr_dec_i   (ctr_dec_i),
        .link_i      (link_i),
        .disp_i      (disp_i),
        .cr_i        (cr_i),
        .lr_i        (lr_i),
        .ctr_i       (ctr_i),
        .next_pc_o   (next_pc_o),
        .taken_o     (taken_o),
        .lr_we_o     (lr_we_o),
        .lr_wdata_o  (lr_wdata_o),
        .ctr_we_o    (ctr_we_o),
        .ctr_wdata_o (ctr_wdata_o)
    );

    task automatic chk(input string what, input logic [23:0] tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        pc_i       = v.pc;
        kind_i     = v.kind;
        cond_en_i  = v.cen;
        cond_sel_i = v.cidx;
        cond_pol_i = v.pol;
        ctr_dec_i  = v.dec;
        link_i     = v.lnk;
        disp_i     = v.disp;
        cr_i       = v.cr;
        lr_i       = v.lr;
        ctr_i      = v.ctr;
    endtask

    task automatic check_vec(input vec_t v, input int idx);
        chk($sformatf("vec %0d next_pc", idx), v.tag, next_pc_o, v.npc);
        chk($sformatf("vec %0d taken", idx), v.tag, 32'(taken_o), 32'(v.tk));
        chk($sformatf("vec %0d lr_we", idx), v.tag, 32'(lr_we_o), 32'(v.lwe));
        if (v.lwe) chk($sformatf("vec %0d lr_wdata", idx), v.tag, lr_wdata_o, v.lwd);
        chk($sformatf("vec %0d ctr_we", idx), v.tag, 32'(ctr_we_o), 32'(v.cwe));
        if (v.cwe) chk($sformatf("vec %0d ctr_wdata", idx), v.tag, ctr_wdata_o, v.cwd);
    endtask

    task automatic check_reset_state(input string when);
        chk({when, " next_pc"}, "R1 ", next_pc_o, RST_PC);
        chk({when, " taken"},   "R1 ", 32'(taken_o), 32'h0);
        chk({when, " lr_we"},   "R1 ", 32'(lr_we_o), 32'h0);
        chk({when, " ctr_we"},  "R1 ", 32'(ctr_we_o), 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state("after reset");          // R1
        rst = 1'b0;

        // Table walk: drive on a falling edge, result one rising edge later.
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            @(negedge clk);
            check_vec(TBL[i], i);
        end

        // R9: new request must not show before the next rising edge.
        drive(TBL[0]);
        #1;
        chk("hold before edge", "R9 ", next_pc_o, TBL[NV-1].npc);
        @(negedge clk);
        chk("update after edge", "R9 ", next_pc_o, TBL[0].npc);

        // R8: back-to-back idle slots step by four each time.
        drive(TBL[13]);
        @(negedge clk);
        pc_i = 32'h0000_0D04;
        @(negedge clk);
        chk("idle sequence", "R8 ", next_pc_o, 32'h0000_0D08);

        // R1: reset during a taken, linking request wins.
        drive(TBL[2]);
        rst = 1'b1;
        @(negedge clk);
        check_reset_state("mid-run reset");
        rst = 1'b0;
        @(negedge clk);
        check_vec(TBL[2], 2);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R9 watchdog: actual hung expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule